// File: doc/BRIEF.md
# Per-Row Column Steering Shifter

This block lets a memory row with one bad bitcell column keep storing a full data word. Each row carries one spare column, so a W-bit word is held in W+1 columns. A small per-row redundancy address says which column of that row is faulty. The address is read out together with the tag, so it arrives here as an input.

On the write side, the encoder shifts every data bit at or above the faulty index up by one column. The faulty column then carries nothing the reader needs. On the read side, the decoder uses the same address to pull each output bit from either its own column or the column above it.

The address is first turned into a thermometer mask, so each stored or returned bit costs exactly one 2:1 mux. An address of W, or any larger value, means the row needs no repair. The block is purely combinational, and its write and read paths are independent.

Top module: `dcr_shifter`

## Requirements
- R1: For every address from 0 to W, decoding the encoded word with the same address returns the original data word.
- R2: For an address a with 0 < a <= W, stored column i equals data bit i for every i < a.
- R3: For an address a with 0 <= a < W, stored column i+1 equals data bit i for every i >= a.
- R4: An address equal to W applies no shift: columns 0 to W-1 equal data bits 0 to W-1, and the spare column W holds a copy of data bit W-1.
- R5: Any address greater than W behaves exactly like an address of W on both the write and the read path.
- R6: The decoded word does not depend on the value read from the column named by the address, nor, when there is no repair, on the spare column W.
- R7: For a read address a, output bit i comes from column i when i < a and from column i+1 when i >= a. For a >= W, output bit i comes from column i for all i.
- R8: Data bit 0 is never dropped. It is written to column 0 when the address is nonzero and to column 1 when the address is 0. Column 0 always holds data bit 0.
- R9: The skipped column a is driven with a defined value: a copy of data bit a-1 when 1 <= a <= W, and data bit 0 when a = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_data | input | W | Data word to be stored |
| wr_ra | input | $clog2(W+1) | Faulty column index for the row being written |
| wr_col | output | W+1 | Column image to write into the row |
| rd_col | input | W+1 | Column image read from the row |
| rd_ra | input | $clog2(W+1) | Faulty column index for the row being read |
| rd_data | output | W | Rebuilt data word |

## Verification
The bound checker evaluates the write and read paths whenever their inputs change. On the write side it checks the bit placement below and above the faulty index and the no-repair copy into the spare column. On the read side it checks the column selection, and it checks the round trip whenever the read side is fed the written image with the same address.

Some properties can only be shown by the bench's scenarios. These are that a deliberately corrupted skipped column leaves the decoded word unchanged, that every address value including the out-of-range ones is covered, and that the defined value on the skipped column holds.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  // Width of the faulty-column index that can also encode "no repair".
  function automatic int ra_bits(input int w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/dcr_therm_gen.sv
module dcr_therm_gen #(
  parameter int NBITS = 65,
  parameter int AW    = 7
) (
  input  logic [AW-1:0]    ra,
  output logic [NBITS-1:0] therm
);
  localparam int RA_EXT = 32;
  logic [RA_EXT-1:0] ra_ext;
  assign ra_ext = RA_EXT'(ra);

  // Bit j is set when j is at or above the faulty index.
  for (genvar j = 0; j < NBITS; j++) begin : g_bit
    assign therm[j] = (ra_ext <= RA_EXT'(j));
  end
endmodule

// File: rtl/dcr_write_shifter.sv
module dcr_write_shifter #(
  parameter int W = 64
) (
  input  logic [W-1:0] data,
  input  logic [W:0]   therm,
  output logic [W:0]   col
);
  for (genvar j = 0; j <= W; j++) begin : g_col
    if (j == 0) begin : g_low
      assign col[j] = data[0];
    end else if (j == W) begin : g_spare
      assign col[j] = data[W-1];
    end else begin : g_mid
      assign col[j] = therm[j] ? data[j-1] : data[j];
    end
  end
endmodule

// File: rtl/dcr_read_shifter.sv
module dcr_read_shifter #(
  parameter int W = 64
) (
  input  logic [W:0]   col,
  input  logic [W-1:0] therm,
  output logic [W-1:0] data
);
  for (genvar i = 0; i < W; i++) begin : g_out
    assign data[i] = therm[i] ? col[i+1] : col[i];
  end
endmodule

// File: rtl/dcr_shifter.sv
module dcr_shifter #(
  parameter int W  = 64,
  parameter int AW = dcr_pkg::ra_bits(W)
) (
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] wr_ra,
  output logic [W:0]    wr_col,
  input  logic [W:0]    rd_col,
  input  logic [AW-1:0] rd_ra,
  output logic [W-1:0]  rd_data
);
  localparam int NCOL = W + 1;

  logic [NCOL-1:0] wr_therm;
  logic [W-1:0]    rd_therm;

  dcr_therm_gen #(.NBITS(NCOL), .AW(AW)) wr_therm_i (
    .ra    (wr_ra),
    .therm (wr_therm)
  );

  // The read mask omits the top bit: no output bit needs it.
  dcr_therm_gen #(.NBITS(W), .AW(AW)) rd_therm_i (
    .ra    (rd_ra),
    .therm (rd_therm)
  );

  dcr_write_shifter #(.W(W)) enc_i (
    .data  (wr_data),
    .therm (wr_therm),
    .col   (wr_col)
  );

  dcr_read_shifter #(.W(W)) dec_i (
    .col   (rd_col),
    .therm (rd_therm),
    .data  (rd_data)
  );
endmodule

// File: rtl/dcr_shifter_chk.sv
module dcr_shifter_chk #(
  parameter int W  = 64,
  parameter int AW = dcr_pkg::ra_bits(W)
) (
  input logic [W-1:0]  wr_data,
  input logic [AW-1:0] wr_ra,
  input logic [W:0]    wr_col,
  input logic [W:0]    rd_col,
  input logic [AW-1:0] rd_ra,
  input logic [W-1:0]  rd_data
);
  always_comb begin
    // R1: loopback of the written image with the same address.
    if (wr_ra == rd_ra && rd_col == wr_col)
      a_r1_round_trip: assert (rd_data == wr_data);
    // R4, R5: no-repair addresses leave the word in place.
    if (int'(wr_ra) >= W) begin
      a_r4_no_shift: assert (wr_col[W-1:0] == wr_data);
      a_r4_spare_copy: assert (wr_col[W] == wr_data[W-1]);
    end
    if (int'(rd_ra) >= W)
      a_r5_read_no_shift: assert (rd_data == rd_col[W-1:0]);
    for (int i = 0; i < W; i++) begin
      if (i < int'(wr_ra))
        a_r2_low_bits: assert (wr_col[i] == wr_data[i]);
      else
        a_r3_high_bits: assert (wr_col[i+1] == wr_data[i]);
      if (i < int'(rd_ra))
        a_r7_read_low: assert (rd_data[i] == rd_col[i]);
      else
        a_r7_read_high: assert (rd_data[i] == rd_col[i+1]);
    end
    // R8: column 0 always carries data bit 0.
    a_r8_bit0_kept: assert (wr_col[0] == wr_data[0]);
  end
endmodule

bind dcr_shifter dcr_shifter_chk #(.W(W), .AW(AW)) chk_i (
  .wr_data (wr_data),
  .wr_ra   (wr_ra),
  .wr_col  (wr_col),
  .rd_col  (rd_col),
  .rd_ra   (rd_ra),
  .rd_data (rd_data)
);

// File: tb/dcr_shifter_tb_top.sv
module dcr_shifter_tb_top;
  localparam int W  = 64;
  localparam int AW = dcr_pkg::ra_bits(W);
  localparam int RA_MAX = (1 << AW) - 1;

  logic clk;
  logic rst_n;
  logic [W-1:0]  wr_data;
  logic [AW-1:0] wr_ra;
  logic [W:0]    wr_col;
  logic [W:0]    rd_col;
  logic [AW-1:0] rd_ra;
  logic [W-1:0]  rd_data;

  int checks;
  int failures;
  bit done;

  dcr_shifter #(.W(W)) dut_i (
    .wr_data (wr_data),
    .wr_ra   (wr_ra),
    .wr_col  (wr_col),
    .rd_col  (rd_col),
    .rd_ra   (rd_ra),
    .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference: placement stated by the requirements.
  function automatic logic [W:0] ref_encode(input logic [W-1:0] d, input int ra);
    logic [W:0] c;
    for (int j = 0; j <= W; j++) begin
      if (ra <= W && j >= ra && j > 0) c[j] = d[j-1];
      else if (j == W)                 c[j] = d[W-1];
      else                             c[j] = d[j];
    end
    return c;
  endfunction

  function automatic logic [W-1:0] ref_decode(input logic [W:0] c, input int ra);
    logic [W-1:0] d;
    for (int i = 0; i < W; i++)
      d[i] = (ra < W && i >= ra) ? c[i+1] : c[i];
    return d;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic run_vector(input int ra, input logic [W-1:0] d);
    logic [W:0] exp_col;
    logic [W:0] bad;
    logic [W:0] rnd;
    exp_col = ref_encode(d, ra);
    bad = exp_col;
    if (ra <= W) bad[ra] = ~bad[ra];
    else         bad[W]  = ~bad[W];
    @(posedge clk);
    wr_data = d;
    wr_ra   = AW'(ra);
    rd_ra   = AW'(ra);
    rd_col  = bad;
    @(negedge clk);
    if (ra > W)       check(wr_col == exp_col, "R5 encode", wr_col, exp_col);
    else if (ra == W) check(wr_col == exp_col, "R4 encode", wr_col, exp_col);
    else if (ra == 0) check(wr_col == exp_col, "R8 encode", wr_col, exp_col);
    else              check(wr_col == exp_col, "R2 R3 encode", wr_col, exp_col);
    if (ra <= W) begin
      check(wr_col[ra] == (ra == 0 ? d[0] : d[ra-1]), "R9 skipped column",
            {{W{1'b0}}, wr_col[ra]}, {{W{1'b0}}, (ra == 0 ? d[0] : d[ra-1])});
      check(rd_data == d, "R1 R6 corrupted loopback",
            {1'b0, rd_data}, {1'b0, d});
    end else begin
      check(rd_data == d, "R5 R6 no-repair loopback",
            {1'b0, rd_data}, {1'b0, d});
    end
    rnd = {$urandom, $urandom, $urandom};
    @(posedge clk);
    rd_col = rnd;
    @(negedge clk);
    check(rd_data == ref_decode(rnd, ra), "R7 decode select",
          {1'b0, rd_data}, {1'b0, ref_decode(rnd, ra)});
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    rst_n = 1'b0;
    wr_data = '0;
    wr_ra = '0;
    rd_ra = '0;
    rd_col = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wr_col == '0, "R8 zero input encode", wr_col, '0);
    check(rd_data == '0, "R7 zero input decode", {1'b0, rd_data}, '0);
    rst_n = 1'b1;
    for (int ra = 0; ra <= RA_MAX; ra++) begin
      run_vector(ra, '1);
      run_vector(ra, {(W/2){2'b10}});
      run_vector(ra, {(W/2){2'b01}});
      run_vector(ra, W'(1) << (ra % W));
      run_vector(ra, {$urandom, $urandom});
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule